// File: doc/BRIEF.md
# Two-Speed Start-up Clock Select Controller

This block decides which clock source feeds the core after a reset and after a wake from sleep. With the fast start-up option enabled and a crystal-type primary oscillator configured, the core runs from the internal oscillator as soon as the power-up timer has expired. It does not have to wait for the crystal. An oscillator start-up timer (OST) counts primary-oscillator ticks, and when it expires the select moves to the primary clock without any action from software.

Primary modes that are not crystal-based need no start-up count. They go straight to the primary clock. If the option is disabled while a crystal mode is configured, the core clock stays gated until the OST expires. When software leaves the primary clock for an alternate run mode and later asks for it back, the block keeps the current source running until the primary is ready. In that path the enable bit has no effect.

The block drives only the select code and the state code. The glitch-free multiplexer that acts on the select lives elsewhere. A 3-bit internal-frequency field also passes through the block. It is frozen for the whole of a sleep period, so the value that was set before sleep is the one in force at wake-up.

Top module: `clksw_twospeed`

## Requirements
- R1: While `rst_n` is low, and one cycle after any cycle with `por_evt` high, `run_mode` is 0 (reset wait) and `clk_sel` is 0 (gated). The OST count restarts from zero on `por_evt`.
- R2: In reset wait, the state holds and `clk_sel` stays 0 for as long as `pwrt_done` is low.
- R3: In reset wait with `pwrt_done` high, `fast_en` high, a crystal `pri_mode` (codes 0 to 3) and the OST not expired, the next state is `run_mode` 1 (internal run) with `clk_sel` 1.
- R4: `ost_done` goes high once `OST_CYCLES` `pri_tick` pulses have been counted since the last restart. In internal run, `ost_done` high moves the block to `run_mode` 2 (primary run, `clk_sel` 2) on the next cycle.
- R5: With a non-crystal `pri_mode` (codes 4 to 7), reset wait with `pwrt_done` high goes directly to primary run, whatever the value of `fast_en`.
- R6: With `fast_en` low and a crystal mode, reset wait keeps the clock gated until `ost_done`, then goes to primary run.
- R7: `sleep_req` in internal, primary or alternate run enters `run_mode` 4 (sleep, `clk_sel` 0). The OST is held cleared while asleep. `wake_evt` with the fast option active (enabled and crystal) goes to internal run.
- R8: On `wake_evt` without the fast option, a crystal mode returns to reset wait (gated until `ost_done`) and a non-crystal mode goes to primary run.
- R9: In primary run, a `src_req` other than 0 enters `run_mode` 3 (alternate run) and restarts the OST. In alternate run, `clk_sel` is 3 when `src_req` is 1 and 1 otherwise. When `src_req` returns to 0, a crystal mode stays in alternate run until `ost_done`, whatever `fast_en` is, and a non-crystal mode returns to primary run at once.
- R10: Outside sleep, `int_freq` takes the value of `ircf` with one cycle of latency. During sleep it holds the value captured on the cycle that entered sleep, and `ircf` writes have no effect.
- R11: `sleep_req` has priority over OST expiry and over source changes, and `por_evt` has priority over every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_evt | input | 1 | Reset event; restarts the start-up sequence |
| pwrt_done | input | 1 | Power-up timer has expired (level) |
| wake_evt | input | 1 | Wake-up event while in sleep |
| sleep_req | input | 1 | Request to enter sleep |
| pri_tick | input | 1 | One pulse per counted primary-oscillator period |
| pri_mode | input | 3 | Primary mode: 0 LP, 1 XT, 2 HS, 3 HSPLL, 4 to 7 non-crystal |
| fast_en | input | 1 | Two-speed start-up enable configuration bit |
| src_req | input | 2 | Requested run source: 0 primary, 1 secondary, 2 or 3 internal |
| ircf | input | 3 | Internal-oscillator frequency select |
| clk_sel | output | 2 | 0 gated, 1 internal, 2 primary, 3 secondary |
| run_mode | output | 3 | 0 reset wait, 1 internal run, 2 primary run, 3 alternate run, 4 sleep |
| int_freq | output | 3 | Frequency select passed to the internal oscillator |
| ost_done | output | 1 | The OST has expired since its last restart |

## Verification
On every cycle the assertions check the one-step transitions: reset-event entry, holding in reset wait while the power-up timer runs, the interim internal phase, the handoff after OST expiry, the direct path for non-crystal modes, the frozen frequency and the hold state during sleep, and the hold in alternate run until the OST expires. The bench's scenarios cover the behaviour that spans many cycles. They show that the OST expires after exactly the configured number of ticks following each restart. They also run full sequences: reset, interim phase, primary run, sleep and wake, with the enable bit set and cleared and across mode codes, and they check that frequency writes made during sleep have no effect.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  typedef enum logic [2:0] {
    ST_RESET_WAIT = 3'd0,
    ST_INTOSC_RUN = 3'd1,
    ST_PRI_RUN    = 3'd2,
    ST_ALT_RUN    = 3'd3,
    ST_SLEEP      = 3'd4
  } run_state_t;

  localparam logic [1:0] SEL_GATED   = 2'd0;
  localparam logic [1:0] SEL_INTOSC  = 2'd1;
  localparam logic [1:0] SEL_PRIMARY = 2'd2;
  localparam logic [1:0] SEL_SECOND  = 2'd3;

  localparam logic [1:0] REQ_PRIMARY = 2'd0;
  localparam logic [1:0] REQ_SECOND  = 2'd1;

  // Crystal-type primary modes occupy codes 0..3.
  function automatic logic mode_is_crystal(input logic [2:0] mode);
    return (mode[2] == 1'b0);
  endfunction

  function automatic logic [1:0] sel_for(input run_state_t st, input logic [1:0] req);
    logic [1:0] s;
    case (st)
      ST_INTOSC_RUN: s = SEL_INTOSC;
      ST_PRI_RUN:    s = SEL_PRIMARY;
      ST_ALT_RUN:    s = (req == REQ_SECOND) ? SEL_SECOND : SEL_INTOSC;
      default:       s = SEL_GATED;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/clksw_ost_timer.sv
module clksw_ost_timer #(
  parameter int OST_CYCLES = 1024,
  localparam int CW = $clog2(OST_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic expired
);
  localparam logic [CW-1:0] LIMIT = CW'(OST_CYCLES);

  logic [CW-1:0] cnt_q;

  assign expired = (cnt_q == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart)          cnt_q <= '0;
    else if (tick && !expired) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/clksw_mode_fsm.sv
module clksw_mode_fsm
  import clksw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_evt,
  input  logic       pwrt_done,
  input  logic       wake_evt,
  input  logic       sleep_req,
  input  logic       ost_done,
  input  logic       crystal,
  input  logic       twospd_act,
  input  logic [1:0] src_req,
  output run_state_t state,
  output logic       ost_clr
);
  run_state_t nxt;

  always_comb begin
    nxt     = state;
    ost_clr = 1'b0;
    if (por_evt) begin
      nxt     = ST_RESET_WAIT;
      ost_clr = 1'b1;
    end else begin
      case (state)
        ST_RESET_WAIT:
          if (pwrt_done && (twospd_act || !crystal || ost_done))
            nxt = (twospd_act && !ost_done) ? ST_INTOSC_RUN : ST_PRI_RUN;
        ST_INTOSC_RUN:
          if (sleep_req)     nxt = ST_SLEEP;
          else if (ost_done) nxt = ST_PRI_RUN;
        ST_PRI_RUN:
          if (sleep_req) nxt = ST_SLEEP;
          else if (src_req != REQ_PRIMARY) begin
            nxt     = ST_ALT_RUN;
            ost_clr = 1'b1;
          end
        ST_ALT_RUN:
          if (sleep_req) nxt = ST_SLEEP;
          else if (src_req == REQ_PRIMARY && (ost_done || !crystal))
            nxt = ST_PRI_RUN;
        ST_SLEEP: begin
          ost_clr = 1'b1;
          if (wake_evt) begin
            if (twospd_act)    nxt = ST_INTOSC_RUN;
            else if (!crystal) nxt = ST_PRI_RUN;
            else               nxt = ST_RESET_WAIT;
          end
        end
        default: nxt = ST_RESET_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET_WAIT;
    else        state <= nxt;
  end
endmodule

// File: rtl/clksw_freq_hold.sv
module clksw_freq_hold #(
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          freeze,
  input  logic [FW-1:0] din,
  output logic [FW-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout <= '0;
    else if (!freeze) dout <= din;
  end
endmodule

// File: rtl/clksw_twospeed.sv
module clksw_twospeed
  import clksw_pkg::*;
#(
  parameter int OST_CYCLES = 1024,
  parameter int FREQ_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_evt,
  input  logic              pwrt_done,
  input  logic              wake_evt,
  input  logic              sleep_req,
  input  logic              pri_tick,
  input  logic [2:0]        pri_mode,
  input  logic              fast_en,
  input  logic [1:0]        src_req,
  input  logic [FREQ_W-1:0] ircf,
  output logic [1:0]        clk_sel,
  output logic [2:0]        run_mode,
  output logic [FREQ_W-1:0] int_freq,
  output logic              ost_done
);
  // Named internal events, visible to the bound checker.
  logic       crystal;
  logic       twospd_act;
  logic       ost_clr;
  logic       in_sleep;
  run_state_t state;

  assign crystal    = mode_is_crystal(pri_mode);
  assign twospd_act = fast_en && crystal;
  assign in_sleep   = (state == ST_SLEEP);

  clksw_ost_timer #(.OST_CYCLES(OST_CYCLES)) u_ost (
    .clk(clk), .rst_n(rst_n), .restart(ost_clr), .tick(pri_tick), .expired(ost_done)
  );

  clksw_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .pwrt_done(pwrt_done),
    .wake_evt(wake_evt), .sleep_req(sleep_req), .ost_done(ost_done),
    .crystal(crystal), .twospd_act(twospd_act), .src_req(src_req),
    .state(state), .ost_clr(ost_clr)
  );

  clksw_freq_hold #(.FW(FREQ_W)) u_freq (
    .clk(clk), .rst_n(rst_n), .freeze(in_sleep), .din(ircf), .dout(int_freq)
  );

  assign clk_sel  = sel_for(state, src_req);
  assign run_mode = state;
endmodule

// File: rtl/clksw_checker.sv
module clksw_checker #(
  parameter int FREQ_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_evt,
  input logic              pwrt_done,
  input logic              wake_evt,
  input logic              sleep_req,
  input logic [2:0]        pri_mode,
  input logic [1:0]        src_req,
  input logic [2:0]        run_mode,
  input logic [1:0]        clk_sel,
  input logic [FREQ_W-1:0] int_freq,
  input logic              ost_done,
  input logic              twospd_act
);
  AST_POR_ENTERS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    por_evt |=> (run_mode == 3'd0 && clk_sel == 2'd0)); // R1

  AST_WAIT_HOLDS_FOR_PWRT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode == 3'd0 && !pwrt_done && !por_evt) |=> (run_mode == 3'd0)); // R2

  AST_INTERIM_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode == 3'd0 && pwrt_done && twospd_act && !ost_done && !por_evt)
      |=> (run_mode == 3'd1 && clk_sel == 2'd1)); // R3

  AST_OST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode == 3'd1 && ost_done && !sleep_req && !por_evt) |=> (run_mode == 3'd2)); // R4

  AST_NONXTAL_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode == 3'd0 && pwrt_done && pri_mode[2] && !por_evt) |=> (run_mode == 3'd2)); // R5

  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode == 3'd4 && !wake_evt && !por_evt) |=> (run_mode == 3'd4 && !ost_done)); // R7

  AST_FREQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode == 3'd4 && !por_evt) |=> $stable(int_freq)); // R10

  AST_ALT_WAITS_OST: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode == 3'd3 && src_req == 2'd0 && !pri_mode[2] && !ost_done
     && !sleep_req && !por_evt) |=> (run_mode == 3'd3)); // R9
endmodule

bind clksw_twospeed clksw_checker #(.FREQ_W(FREQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .pwrt_done(pwrt_done),
  .wake_evt(wake_evt), .sleep_req(sleep_req), .pri_mode(pri_mode),
  .src_req(src_req), .run_mode(run_mode), .clk_sel(clk_sel),
  .int_freq(int_freq), .ost_done(ost_done), .twospd_act(twospd_act)
);

// File: tb/tb_clksw_twospeed.sv
module tb_clksw_twospeed;
  localparam int OSTN = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_evt = 0, pwrt_done = 0, wake_evt = 0, sleep_req = 0, pri_tick = 0, fast_en = 0;
  logic [2:0] pri_mode = 3'd1;
  logic [1:0] src_req = 2'd0;
  logic [2:0] ircf = 3'd0;
  logic [1:0] clk_sel;
  logic [2:0] run_mode;
  logic [2:0] int_freq;
  logic       ost_done;

  always #4 clk = ~clk; // 125 MHz

  clksw_twospeed #(.OST_CYCLES(OSTN), .FREQ_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .pwrt_done(pwrt_done),
    .wake_evt(wake_evt), .sleep_req(sleep_req), .pri_tick(pri_tick),
    .pri_mode(pri_mode), .fast_en(fast_en), .src_req(src_req), .ircf(ircf),
    .clk_sel(clk_sel), .run_mode(run_mode), .int_freq(int_freq), .ost_done(ost_done)
  );

  // Behavioural reference model.
  int m_st = 0, m_cnt = 0, m_frq = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_cnt <= 0; m_frq <= 0;
    end else begin
      int ns; bit xtal, fast, done, clr;
      xtal = (pri_mode < 3'd4);
      fast = xtal && fast_en;
      done = (m_cnt == OSTN);
      ns = m_st; clr = 0;
      if (por_evt) begin ns = 0; clr = 1; end
      else if (m_st == 4) begin
        clr = 1;
        if (wake_evt) ns = fast ? 1 : (!xtal ? 2 : 0);
      end else if (m_st != 0 && sleep_req) ns = 4;
      else if (m_st == 0) begin
        if (pwrt_done && !xtal) ns = 2;
        else if (pwrt_done && done) ns = 2;
        else if (pwrt_done && fast) ns = 1;
      end else if (m_st == 1) begin
        if (done) ns = 2;
      end else if (m_st == 2) begin
        if (src_req != 0) begin ns = 3; clr = 1; end
      end else if (m_st == 3) begin
        if (src_req == 0 && (done || !xtal)) ns = 2;
      end
      m_st <= ns;
      if (clr) m_cnt <= 0;
      else if (pri_tick && m_cnt < OSTN) m_cnt <= m_cnt + 1;
      if (m_st != 4) m_frq <= ircf;
    end
  end

  int vectors = 0, miscompares = 0;
  string cur_req = "R1";

  task automatic check();
    int es;
    vectors++;
    case (m_st)
      1: es = 1;
      2: es = 2;
      3: es = (src_req == 2'd1) ? 3 : 1;
      default: es = 0;
    endcase
    if (run_mode != 3'(m_st) || clk_sel != 2'(es) || int_freq != 3'(m_frq)
        || ost_done != (m_cnt == OSTN)) begin
      miscompares++;
      $display("FAIL %s t=%0t: mode=%0d sel=%0d freq=%0d ost=%0d, expected mode=%0d sel=%0d freq=%0d ost=%0d",
               cur_req, $time, run_mode, clk_sel, int_freq, ost_done,
               m_st, es, m_frq, (m_cnt == OSTN));
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check();
    end
  endtask

  task automatic por_pulse();
    por_evt = 1; cyc(1); por_evt = 0;
  endtask

  bit finished = 0;
  initial begin
    for (int w = 0; w < 20000; w++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    pri_tick = 1; fast_en = 1; pri_mode = 3'd1; ircf = 3'd5;
    cyc(3);
    @(negedge clk); rst_n = 1;
    // R2: gated while power-up timer runs
    cur_req = "R2"; cyc(5);
    // R3: interim internal-clock phase (XT, enabled)
    cur_req = "R3"; pwrt_done = 1; cyc(2);
    // R10: frequency follows outside sleep
    cur_req = "R10"; ircf = 3'd2; cyc(2);
    // R4: OST expiry hands off to primary
    cur_req = "R4"; cyc(OSTN);
    // R7: sleep, frozen freq, wake into interim phase
    cur_req = "R7"; ircf = 3'd6; sleep_req = 1; cyc(1); sleep_req = 0;
    cur_req = "R10"; ircf = 3'd1; cyc(4);
    cur_req = "R7"; wake_evt = 1; cyc(1); wake_evt = 0; cyc(4);
    // R11: sleep beats OST expiry
    cur_req = "R11"; cyc(OSTN - 5); sleep_req = 1; cyc(1); sleep_req = 0; cyc(2);
    wake_evt = 1; cyc(1); wake_evt = 0; cyc(OSTN + 2);
    // R5: non-crystal mode goes straight to primary, enable set and clear
    cur_req = "R5"; pri_mode = 3'd5; por_pulse(); cyc(3);
    fast_en = 0; pri_mode = 3'd7; por_pulse(); cyc(3);
    // R6: disabled crystal mode waits gated for OST
    cur_req = "R6"; pri_mode = 3'd2; por_pulse(); cyc(OSTN + 3);
    // R8: wake without fast option
    cur_req = "R8"; sleep_req = 1; cyc(1); sleep_req = 0; cyc(2);
    wake_evt = 1; cyc(1); wake_evt = 0; cyc(OSTN + 3);
    pri_mode = 3'd4; sleep_req = 1; cyc(1); sleep_req = 0; cyc(2);
    wake_evt = 1; cyc(1); wake_evt = 0; cyc(3);
    // R9: alternate sources, return waits for OST regardless of enable
    cur_req = "R9"; pri_mode = 3'd3; fast_en = 1; cyc(2);
    src_req = 2'd2; cyc(3); src_req = 2'd1; cyc(3);
    src_req = 2'd0; cyc(OSTN + 3);
    pri_mode = 3'd6; src_req = 2'd1; cyc(3); src_req = 2'd0; cyc(3);
    // R11: reset event dominates a simultaneous sleep request
    cur_req = "R11"; pri_mode = 3'd0; sleep_req = 1; por_evt = 1; cyc(1);
    sleep_req = 0; por_evt = 0; cyc(OSTN + 3);
    // R4: ticks paused stall the OST
    cur_req = "R4"; por_pulse(); pri_tick = 0; cyc(6); pri_tick = 1; cyc(OSTN + 2);
    // R1: asynchronous reset mid-run
    cur_req = "R1"; @(negedge clk); rst_n = 0; cyc(2); rst_n = 1; cyc(3);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule